// File: doc/BRIEF.md
# Sample ROM Bank Decoder

This block sits between a sound processor that uses a 24-bit byte address bus and a 16 MB sample ROM. On every CPU read it decides which target is addressed: one of two sound-chip register windows, or the sample ROM. For sample reads it also produces the translated ROM offset. Everything it does is combinational from the CPU address and a single registered bank bit.

The top 8 MB of CPU space (0x800000 and up) is the sample area. The first 2 MB of that area, 0x800000–0x9FFFFF, is fixed to ROM offsets 0x000000–0x1FFFFF. The two windows above it (0xA00000–0xDFFFFF and 0xE00000–0xFFFFFF) move together under control of one bit in a write-only bank register. A configuration input states whether 8 MB or 16 MB of ROM is populated. With 8 MB fitted, ROM offset bit 23 is forced low, so the upper half of the offset space mirrors the lower half. Any access that decodes to nothing raises an unmapped flag for as long as its strobe is held.

Top module: `smp_bank_decoder`

## Requirements
- R1: After reset the bank bit is clear, so a word read of CPU 0xA00000 addresses ROM 0x200000.
- R2: Only a byte write (`cpu_byte`=1) to CPU 0x400001 loads the bank bit, and it takes bit 4 of `cpu_wdata` (mask 0x10). The other data bits are ignored. The new value applies from the next clock cycle.
- R3: With the bank bit set, CPU 0xA00000–0xDFFFFF maps to ROM 0xA00000–0xDFFFFF, and CPU 0xE00000–0xFFFFFF maps to ROM 0xE00000–0xFFFFFF.
- R4: With the bank bit clear, CPU 0xA00000–0xDFFFFF maps to ROM 0x200000–0x5FFFFF, and CPU 0xE00000–0xFFFFFF maps to ROM 0x600000–0x7FFFFF.
- R5: CPU 0x800000–0x9FFFFF always maps to ROM 0x000000–0x1FFFFF, whatever the bank bit holds.
- R6: A byte read (`cpu_byte`=1) from any sample window inverts bit 0 of the ROM address. A word read (`cpu_byte`=0) leaves bit 0 unchanged.
- R7: When `rom_is_16m`=0, ROM address bit 23 is driven 0 on every sample read.
- R8: A read of 0x100000–0x10FFFF asserts `chip_a_sel`, and a read of 0x300000–0x30FFFF asserts `chip_b_sel`. At most one of `rom_sel`, `chip_a_sel`, `chip_b_sel` and `unmapped` is high at a time.
- R9: `unmapped` is high in the same cycle as any of the following, and nothing is selected: a read outside all windows; a read of 0x400001; any write except the bank byte write; an access with both strobes high. It is low when no strobe is active.
- R10: An unmapped access, including a word write to 0x400000, leaves the bank bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 24 | CPU byte address |
| cpu_byte | input | 1 | 1 = byte access, 0 = 16-bit word access |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe |
| cpu_wdata | input | 8 | Write data byte |
| rom_is_16m | input | 1 | 1 = 16 MB of sample ROM fitted, 0 = 8 MB |
| rom_addr | output | 24 | Translated sample ROM byte offset |
| rom_sel | output | 1 | Sample ROM read select |
| chip_a_sel | output | 1 | First sound-chip register window select |
| chip_b_sel | output | 1 | Second sound-chip register window select |
| unmapped | output | 1 | Access decoded to no target |

## Verification
The assertions take for granted that `rom_is_16m` is static while a read is in flight. They also rely on the address and strobes being stable from the start of a cycle to its closing clock edge, because the bank bit is sampled against the same address that the outputs are decoded from. The bench drives every access, including each bank write, on the falling edge and holds it for exactly one full cycle. Configuration changes only happen between accesses. This keeps every checked cycle inside those assumptions, and it also makes each unmapped access a single-cycle pulse.

// File: rtl/smp_bank_decoder.sv
module smp_bank_decoder #(
  parameter int          AW          = 24,
  parameter int          BANK_BIT    = 4,
  parameter int          CHIP_SPAN_W = 16,
  parameter logic [23:0] BANK_ADDR   = 24'h400001,
  parameter logic [23:0] CHIP_A_BASE = 24'h100000,
  parameter logic [23:0] CHIP_B_BASE = 24'h300000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] cpu_addr,
  input  logic          cpu_byte,
  input  logic          cpu_rd,
  input  logic          cpu_wr,
  input  logic [7:0]    cpu_wdata,
  input  logic          rom_is_16m,
  output logic [AW-1:0] rom_addr,
  output logic          rom_sel,
  output logic          chip_a_sel,
  output logic          chip_b_sel,
  output logic          unmapped
);

  localparam int TAG_W = AW - CHIP_SPAN_W;

  logic          bank_q;
  logic          rd_acc, wr_acc, bank_wr;
  logic          smp_win, fixed_win, chip_a_hit, chip_b_hit;
  logic [AW-1:0] offs;

  assign rd_acc  = cpu_rd & ~cpu_wr;
  assign wr_acc  = cpu_wr & ~cpu_rd;
  assign bank_wr = wr_acc & cpu_byte & (cpu_addr == BANK_ADDR[AW-1:0]);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       bank_q <= 1'b0;
    else if (bank_wr) bank_q <= cpu_wdata[BANK_BIT];

  assign smp_win    = cpu_addr[AW-1];
  assign fixed_win  = smp_win & (cpu_addr[AW-2:AW-3] == 2'b00);
  assign chip_a_hit = cpu_addr[AW-1:CHIP_SPAN_W] == CHIP_A_BASE[AW-1:CHIP_SPAN_W];
  assign chip_b_hit = cpu_addr[AW-1:CHIP_SPAN_W] == CHIP_B_BASE[AW-1:CHIP_SPAN_W];

  // banked windows keep the CPU address when the bit is set, else drop 8 MB
  assign offs     = (bank_q & ~fixed_win) ? cpu_addr : {1'b0, cpu_addr[AW-2:0]};
  assign rom_addr = {offs[AW-1] & rom_is_16m, offs[AW-2:1], offs[0] ^ cpu_byte};

  assign rom_sel    = rd_acc & smp_win;
  assign chip_a_sel = rd_acc & chip_a_hit;
  assign chip_b_sel = rd_acc & chip_b_hit;
  assign unmapped   = (cpu_rd | cpu_wr) & ~(rom_sel | chip_a_sel | chip_b_sel | bank_wr);

  p_bank_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_wr && !cpu_rd && cpu_byte && cpu_addr == BANK_ADDR[AW-1:0]) |=> $stable(bank_q));

  p_bank_set_map_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_sel && bank_q && rom_is_16m && !cpu_byte && cpu_addr[AW-2:AW-3] != 2'b00)
      |-> rom_addr == cpu_addr);

  p_fixed_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_sel && cpu_addr[AW-2:AW-3] == 2'b00) |-> rom_addr[AW-1:AW-3] == 3'b000);

  p_mirror_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_sel && !rom_is_16m) |-> !rom_addr[AW-1]);

  p_word_lsb_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rom_sel |-> (rom_addr[0] == (cpu_addr[0] ^ cpu_byte)));

  p_one_target_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rom_sel, chip_a_sel, chip_b_sel, unmapped}));

  p_strobe_needed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_rd || cpu_wr) |-> !(rom_sel || chip_a_sel || chip_b_sel || unmapped));

endmodule

// File: tb/sim_smp_bank_decoder.sv
module sim_smp_bank_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] cpu_addr = '0;
  logic        cpu_byte = 1'b0, cpu_rd = 1'b0, cpu_wr = 1'b0, rom_is_16m = 1'b1;
  logic [7:0]  cpu_wdata = '0;
  logic [23:0] rom_addr;
  logic        rom_sel, chip_a_sel, chip_b_sel, unmapped;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  smp_bank_decoder u0 (.clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_byte(cpu_byte),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .rom_is_16m(rom_is_16m),
    .rom_addr(rom_addr), .rom_sel(rom_sel), .chip_a_sel(chip_a_sel), .chip_b_sel(chip_b_sel),
    .unmapped(unmapped));

  // {req, rd wr byte cfg16, addr, wdata, exp rom chipA chipB unmapped, exp rom_addr}
  localparam int NV = 27;
  localparam logic [67:0] VEC [NV] = '{
    {4'd1,  4'b1001, 24'hA00000, 8'h00, 4'b1000, 24'h200000}, // R1 R4
    {4'd4,  4'b1001, 24'hE00000, 8'h00, 4'b1000, 24'h600000}, // R4
    {4'd6,  4'b1011, 24'hDFFFFF, 8'h00, 4'b1000, 24'h5FFFFE}, // R6 R4
    {4'd6,  4'b1011, 24'hFFFFFE, 8'h00, 4'b1000, 24'h7FFFFF}, // R6
    {4'd5,  4'b1001, 24'h800000, 8'h00, 4'b1000, 24'h000000}, // R5
    {4'd5,  4'b1011, 24'h9FFFFF, 8'h00, 4'b1000, 24'h1FFFFE}, // R5 R6
    {4'd2,  4'b0111, 24'h400001, 8'hEF, 4'b0000, 24'h000000}, // R2 bit 4 clear
    {4'd2,  4'b1001, 24'hA00002, 8'h00, 4'b1000, 24'h200002}, // R2 other bits ignored
    {4'd9,  4'b1111, 24'h400001, 8'h10, 4'b0001, 24'h000000}, // R9 both strobes
    {4'd10, 4'b1001, 24'hE00000, 8'h00, 4'b1000, 24'h600000}, // R10 bank kept
    {4'd2,  4'b0111, 24'h400001, 8'h10, 4'b0000, 24'h000000}, // R2 set bank
    {4'd3,  4'b1001, 24'hA00000, 8'h00, 4'b1000, 24'hA00000}, // R3
    {4'd3,  4'b1011, 24'hE00001, 8'h00, 4'b1000, 24'hE00000}, // R3 R6
    {4'd3,  4'b1001, 24'hDFFFFE, 8'h00, 4'b1000, 24'hDFFFFE}, // R3
    {4'd5,  4'b1001, 24'h800004, 8'h00, 4'b1000, 24'h000004}, // R5 bank set
    {4'd8,  4'b1011, 24'h100000, 8'h00, 4'b0100, 24'h000000}, // R8
    {4'd8,  4'b1001, 24'h30FFFE, 8'h00, 4'b0010, 24'h000000}, // R8
    {4'd9,  4'b1001, 24'h110000, 8'h00, 4'b0001, 24'h000000}, // R9 outside
    {4'd9,  4'b1011, 24'h400001, 8'h00, 4'b0001, 24'h000000}, // R9 read of bank reg
    {4'd9,  4'b0111, 24'h100000, 8'h00, 4'b0001, 24'h000000}, // R9 chip write
    {4'd10, 4'b0101, 24'h400000, 8'h00, 4'b0001, 24'h000000}, // R10 word write
    {4'd10, 4'b1001, 24'hA00000, 8'h00, 4'b1000, 24'hA00000}, // R10 still set
    {4'd7,  4'b1000, 24'hA00000, 8'h00, 4'b1000, 24'h200000}, // R7 mirror
    {4'd7,  4'b1000, 24'hFFFFFE, 8'h00, 4'b1000, 24'h7FFFFE}, // R7
    {4'd2,  4'b0111, 24'h400001, 8'h00, 4'b0000, 24'h000000}, // R2 clear bank
    {4'd4,  4'b1001, 24'hE00002, 8'h00, 4'b1000, 24'h600002}, // R4 restored
    {4'd9,  4'b0001, 24'hFFFFFF, 8'h00, 4'b0000, 24'h000000}  // R9 idle, no pulse
  };

  task automatic drive(input logic rd, wr, bt, c16, input logic [23:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_rd = rd; cpu_wr = wr; cpu_byte = bt; rom_is_16m = c16; cpu_addr = a; cpu_wdata = d;
    #2;
  endtask

  task automatic check(input int req, input logic [3:0] ef, input logic [23:0] ea);
    logic [3:0] af;
    af = {rom_sel, chip_a_sel, chip_b_sel, unmapped};
    n_cmp++;
    if (af !== ef || (ef[3] && rom_addr !== ea)) begin
      n_bad++;
      $display("FAIL R%0d: sel/ca/cb/un=%b rom_addr=%h, expected %b %h", req, af, rom_addr, ef, ea);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #2;
    check(9, 4'b0000, 24'h0); // R9 no strobe during reset
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][63], VEC[i][62], VEC[i][61], VEC[i][60], VEC[i][59:36], VEC[i][35:28]);
      check(int'(VEC[i][67:64]), VEC[i][27:24], VEC[i][23:0]);
    end
    // R2 bank applies next cycle: set, then read in the following cycle
    drive(0, 1, 1, 1, 24'h400001, 8'hFF);
    drive(1, 0, 0, 1, 24'hE00000, 8'h00);
    check(2, 4'b1000, 24'hE00000);
    // R1 reset returns bank to clear mapping
    drive(0, 0, 0, 1, 24'h0, 8'h00);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    drive(1, 0, 0, 1, 24'hA00000, 8'h00);
    check(1, 4'b1000, 24'h200000);
    // R9 single-cycle pulse: unmapped read then idle
    drive(1, 0, 0, 1, 24'h000000, 8'h00);
    check(9, 4'b0001, 24'h0);
    drive(0, 0, 0, 1, 24'h000000, 8'h00);
    check(9, 4'b0000, 24'h0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule